// File: doc/BRIEF.md
# Fetch Target Queue

This block sits between a branch-prediction stage and a pipelined instruction-cache fetch stage. The predictor writes one fetch-block descriptor per cycle: the address the block starts at (a branch target), the fall-through address just past its closing strongly biased branch, the address predicted to follow the block, and a flag saying whether the block is wider than one cache line. The queue holds these descriptors so the predictor can run ahead of the fetch stage, and the two sides can have different latencies as long as each moves one block per cycle when not stalled.

On the consumer side the oldest descriptor is turned into cache requests. A block without the wide flag goes out as one request at its start address. A flagged block goes out as one request per cache line it touches: first the start address, then each later line-aligned address, until the line holding the last byte before the fall-through address. The descriptor leaves the queue when its final request is accepted. A redirect after a misprediction empties the queue in one cycle. The queue reports full, empty and its occupancy, plus two running counters of empty cycles and full cycles for occupancy measurement.

Top module: `fetch_target_queue`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `full_o`=0, `count_o`=0, `req_valid_o`=0, `push_stall_o`=0 and both cycle counters read 0.
- R2: Descriptors reach the request port in the order they were accepted, and a request held with `req_ready_i`=0 keeps its address on the next cycle.
- R3: A descriptor with `push_oversize_i`=0 produces exactly one request at its start address with `req_last_o`=1, even if it spans several lines, so one block per cycle flows when both sides are active.
- R4: A descriptor with `push_oversize_i`=1 produces one request per line of `LINE_BYTES` bytes: the start address, then successive line-aligned addresses; `req_last_o`=1 on the request whose next line base is at or beyond the fall-through address (a flagged block inside one line yields one request).
- R5: When the queue is full and no final request is accepted that cycle, `push_stall_o`=1 and the push is dropped; the dropped descriptor never appears at the request port.
- R6: A push and a final-request pop in the same cycle on a full queue both take effect: occupancy stays at `DEPTH` and no entry is lost.
- R7: `req_valid_o` is 0 whenever the queue is empty.
- R8: `flush_i` empties the queue on the next edge, overriding any push or pop in that cycle, and abandons a partly issued wide block.
- R9: `count_o` equals accepted pushes minus completed pops since the last flush or reset, never exceeds `DEPTH`, and `full_o`/`empty_o` reflect `count_o`=`DEPTH`/0.
- R10: `empty_cycles_o` and `full_cycles_o` each increase by one on every clock edge out of reset at which `empty_o` or `full_o` respectively was 1.
- R11: `req_next_o` shows the predicted next address of the descriptor currently issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Redirect: discard all entries |
| push_valid_i | input | 1 | Predictor offers a descriptor |
| push_start_i | input | 32 | Block start address |
| push_fall_i | input | 32 | Fall-through address (first byte after the block) |
| push_next_i | input | 32 | Predicted next block address |
| push_oversize_i | input | 1 | Block wider than one cache line |
| push_stall_o | output | 1 | Push not accepted this cycle |
| req_valid_o | output | 1 | Cache request available |
| req_ready_i | input | 1 | Cache accepts the request |
| req_addr_o | output | 32 | Request address |
| req_next_o | output | 32 | Predicted next address of the issuing block |
| req_last_o | output | 1 | Final request of the block |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds no entry |
| count_o | output | $clog2(DEPTH+1) | Occupancy |
| empty_cycles_o | output | CNT_W | Count of empty cycles |
| full_cycles_o | output | CNT_W | Count of full cycles |

## Verification
The checker assumes that a wide block's fall-through address lies after its start address and that stepping line by line toward it does not wrap the address space; it also assumes reset is held for at least one clock edge. The bench only pushes blocks whose fall-through address exceeds the start, places all addresses far from the top of the address space, and keeps the run short enough that the cycle counters never wrap.

// File: rtl/ftq_pkg.sv
// Package: shared widths and the descriptor type for the fetch target queue.
// Assumes a single address width for every descriptor field.
package ftq_pkg;

    localparam int FTQ_AW = 32;

    typedef struct packed {
        logic [FTQ_AW-1:0] start_addr;
        logic [FTQ_AW-1:0] fall_addr;
        logic [FTQ_AW-1:0] next_addr;
        logic              wide;
    } ftq_desc_t;

endpackage

// File: rtl/ftq_store.sv
// Module: ftq_store
// Holds DEPTH descriptors in registers; one write port and one
// asynchronous read port addressed by the head pointer.
// Assumes the controller never writes a slot that is still being read
// unless it is also popping that slot in the same cycle.
module ftq_store
    import ftq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  ftq_desc_t        wr_data_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    output ftq_desc_t        rd_data_o
);

    ftq_desc_t slot_q [DEPTH];

    // Write the incoming descriptor into the slot the tail points to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_en_i && (wr_ptr_i == PTR_W'(i))) begin
                    slot_q[i] <= wr_data_i;
                end
            end
        end
    end

    // Present the head slot.
    always_comb begin
        rd_data_o = slot_q[rd_ptr_i];
    end

endmodule

// File: rtl/ftq_ptrs.sv
// Module: ftq_ptrs
// Head/tail pointers, occupancy and flow control. Flush outranks push
// and pop; a push on a full queue succeeds only when a pop happens in
// the same cycle.
// Assumes pop_i is only raised while an entry is present.
module ftq_ptrs #(
    parameter int DEPTH    = 8,
    parameter int PTR_W    = 3,
    parameter int CNT_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                push_req_i,
    input  logic                pop_i,
    output logic                wr_en_o,
    output logic [PTR_W-1:0]    wr_ptr_o,
    output logic [PTR_W-1:0]    rd_ptr_o,
    output logic [CNT_BITS-1:0] count_o,
    output logic                full_o,
    output logic                empty_o,
    output logic                stall_o
);

    logic [PTR_W-1:0]    wr_ptr_q, rd_ptr_q;
    logic [PTR_W-1:0]    wr_nxt, rd_nxt;
    logic [CNT_BITS-1:0] count_q;
    logic                push_ok, pop_ok;

    // Pointer advance: plain wrap for power-of-two depth, explicit wrap otherwise.
    if ((2 ** PTR_W) == DEPTH) begin : g_pow2
        assign wr_nxt = wr_ptr_q + PTR_W'(1);
        assign rd_nxt = rd_ptr_q + PTR_W'(1);
    end else begin : g_wrap
        assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
        assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
    end

    // Derive status and decide which operations take effect.
    always_comb begin
        full_o  = (count_q == CNT_BITS'(DEPTH));
        empty_o = (count_q == '0);
        stall_o = full_o && !pop_i;
        push_ok = push_req_i && !stall_o && !flush_i;
        pop_ok  = pop_i && !empty_o && !flush_i;
        wr_en_o = push_ok;
    end

    // Update pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= wr_nxt;
            end
            if (pop_ok) begin
                rd_ptr_q <= rd_nxt;
            end
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + CNT_BITS'(1);
                2'b01:   count_q <= count_q - CNT_BITS'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign wr_ptr_o = wr_ptr_q;
    assign rd_ptr_o = rd_ptr_q;
    assign count_o  = count_q;

endmodule

// File: rtl/ftq_line_split.sv
// Module: ftq_line_split
// Turns the head descriptor into cache requests. A narrow block gives a
// single request; a wide block gives one request per cache line, and the
// head is released when the final request is accepted.
// Assumes LINE_BYTES is a power of two and a wide block does not wrap
// the address space.
module ftq_line_split
    import ftq_pkg::*;
#(
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              head_valid_i,
    input  ftq_desc_t         head_i,
    input  logic              req_ready_i,
    output logic              req_valid_o,
    output logic [FTQ_AW-1:0] req_addr_o,
    output logic [FTQ_AW-1:0] req_next_o,
    output logic              req_last_o,
    output logic              pop_o
);

    localparam logic [FTQ_AW-1:0] LINE_MASK = FTQ_AW'(LINE_BYTES - 1);
    localparam logic [FTQ_AW-1:0] LINE_STEP = FTQ_AW'(LINE_BYTES);

    logic              mid_q;
    logic [FTQ_AW-1:0] line_q;
    logic [FTQ_AW-1:0] next_base;

    // Select the current request address and decide whether it is the final one.
    always_comb begin
        req_valid_o = head_valid_i;
        req_addr_o  = mid_q ? line_q : head_i.start_addr;
        req_next_o  = head_i.next_addr;
        next_base   = (req_addr_o & ~LINE_MASK) + LINE_STEP;
        req_last_o  = !head_i.wide || (next_base >= head_i.fall_addr);
        pop_o       = req_valid_o && req_ready_i && req_last_o;
    end

    // Track progress through a wide block.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            mid_q  <= 1'b0;
            line_q <= '0;
        end else if (req_valid_o && req_ready_i) begin
            if (req_last_o) begin
                mid_q <= 1'b0;
            end else begin
                mid_q  <= 1'b1;
                line_q <= next_base;
            end
        end
    end

endmodule

// File: rtl/ftq_occ_stats.sv
// Module: ftq_occ_stats
// Free-running tallies of cycles spent empty and cycles spent full.
// Assumes the counters may wrap after 2**CNT_W cycles.
module ftq_occ_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             empty_i,
    input  logic             full_i,
    output logic [CNT_W-1:0] empty_cycles_o,
    output logic [CNT_W-1:0] full_cycles_o
);

    // Accumulate one per cycle for each observed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_cycles_o <= '0;
            full_cycles_o  <= '0;
        end else begin
            if (empty_i) begin
                empty_cycles_o <= empty_cycles_o + CNT_W'(1);
            end
            if (full_i) begin
                full_cycles_o <= full_cycles_o + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/fetch_target_queue.sv
// Module: fetch_target_queue
// Decoupling queue between branch prediction and a pipelined instruction
// cache. Stores fetch-block descriptors, splits wide blocks into per-line
// requests, supports a one-cycle flush and exposes occupancy tallies.
// Assumes DEPTH >= 2 and LINE_BYTES is a power of two.
module fetch_target_queue
    import ftq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int LINE_BYTES = 32,
    parameter int CNT_W      = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       push_valid_i,
    input  logic [FTQ_AW-1:0]          push_start_i,
    input  logic [FTQ_AW-1:0]          push_fall_i,
    input  logic [FTQ_AW-1:0]          push_next_i,
    input  logic                       push_oversize_i,
    output logic                       push_stall_o,
    output logic                       req_valid_o,
    input  logic                       req_ready_i,
    output logic [FTQ_AW-1:0]          req_addr_o,
    output logic [FTQ_AW-1:0]          req_next_o,
    output logic                       req_last_o,
    output logic                       full_o,
    output logic                       empty_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic [CNT_W-1:0]           empty_cycles_o,
    output logic [CNT_W-1:0]           full_cycles_o
);

    localparam int PTR_W    = $clog2(DEPTH);
    localparam int CNT_BITS = $clog2(DEPTH + 1);

    ftq_desc_t        wr_desc, head_desc;
    logic             wr_en, pop;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Bundle the predictor's fields into one descriptor.
    always_comb begin
        wr_desc.start_addr = push_start_i;
        wr_desc.fall_addr  = push_fall_i;
        wr_desc.next_addr  = push_next_i;
        wr_desc.wide       = push_oversize_i;
    end

    ftq_ptrs #(
        .DEPTH   (DEPTH),
        .PTR_W   (PTR_W),
        .CNT_BITS(CNT_BITS)
    ) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .push_req_i(push_valid_i),
        .pop_i     (pop),
        .wr_en_o   (wr_en),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .count_o   (count_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .stall_o   (push_stall_o)
    );

    ftq_store #(
        .DEPTH(DEPTH),
        .PTR_W(PTR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_ptr_i (wr_ptr),
        .wr_data_i(wr_desc),
        .rd_ptr_i (rd_ptr),
        .rd_data_o(head_desc)
    );

    ftq_line_split #(
        .LINE_BYTES(LINE_BYTES)
    ) u_split (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .head_valid_i(!empty_o),
        .head_i      (head_desc),
        .req_ready_i (req_ready_i),
        .req_valid_o (req_valid_o),
        .req_addr_o  (req_addr_o),
        .req_next_o  (req_next_o),
        .req_last_o  (req_last_o),
        .pop_o       (pop)
    );

    ftq_occ_stats #(
        .CNT_W(CNT_W)
    ) u_stats (
        .clk           (clk),
        .rst_n         (rst_n),
        .empty_i       (empty_o),
        .full_i        (full_o),
        .empty_cycles_o(empty_cycles_o),
        .full_cycles_o (full_cycles_o)
    );

endmodule

// File: rtl/ftq_checker.sv
// Module: ftq_checker
// Port-level properties of the fetch target queue, bound to the top.
// Assumes reset is held for at least one edge before release.
module ftq_checker #(
    parameter int DEPTH    = 8,
    parameter int CNT_W    = 16,
    parameter int AW       = 32,
    parameter int CNT_BITS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush_i,
    input logic                push_valid_i,
    input logic                push_stall_o,
    input logic                req_valid_o,
    input logic                req_ready_i,
    input logic [AW-1:0]       req_addr_o,
    input logic                req_last_o,
    input logic                full_o,
    input logic                empty_o,
    input logic [CNT_BITS-1:0] count_o,
    input logic [CNT_W-1:0]    empty_cycles_o,
    input logic [CNT_W-1:0]    full_cycles_o
);

    logic pop_seen;
    assign pop_seen = req_valid_o && req_ready_i && req_last_o;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count_o <= CNT_BITS'(DEPTH)); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !flush_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_BITS'(1)) || (count_o + CNT_BITS'(1) == $past(count_o))); // R9
    AST_NO_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty_o |-> !req_valid_o); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush_i |=> empty_o && (count_o == '0) && !req_valid_o); // R8
    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n) full_o && !pop_seen |-> push_stall_o); // R5
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n) full_o && push_valid_i && pop_seen && !flush_i |=> full_o); // R6
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid_o && !req_ready_i && !flush_i |=> req_valid_o && $stable(req_addr_o)); // R2
    AST_EMPTY_TALLY: assert property (@(posedge clk) disable iff (!rst_n) empty_o |=> empty_cycles_o == CNT_W'($past(empty_cycles_o) + CNT_W'(1))); // R10
    AST_FULL_TALLY: assert property (@(posedge clk) disable iff (!rst_n) full_o |=> full_cycles_o == CNT_W'($past(full_cycles_o) + CNT_W'(1))); // R10

endmodule

bind fetch_target_queue ftq_checker #(
    .DEPTH   (DEPTH),
    .CNT_W   (CNT_W),
    .AW      (ftq_pkg::FTQ_AW),
    .CNT_BITS($clog2(DEPTH+1))
) u_ftq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .push_valid_i  (push_valid_i),
    .push_stall_o  (push_stall_o),
    .req_valid_o   (req_valid_o),
    .req_ready_i   (req_ready_i),
    .req_addr_o    (req_addr_o),
    .req_last_o    (req_last_o),
    .full_o        (full_o),
    .empty_o       (empty_o),
    .count_o       (count_o),
    .empty_cycles_o(empty_cycles_o),
    .full_cycles_o (full_cycles_o)
);

// File: tb/fetch_target_queue_bench.sv
module fetch_target_queue_bench;

    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        push_valid_i = 1'b0;
    logic [31:0] push_start_i = '0;
    logic [31:0] push_fall_i = '0;
    logic [31:0] push_next_i = '0;
    logic        push_oversize_i = 1'b0;
    logic        req_ready_i = 1'b0;
    logic        push_stall_o, req_valid_o, req_last_o, full_o, empty_o;
    logic [31:0] req_addr_o, req_next_o;
    logic [3:0]  count_o;
    logic [15:0] empty_cycles_o, full_cycles_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fetch_target_queue u_fetch_target_queue (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .push_valid_i(push_valid_i), .push_start_i(push_start_i),
        .push_fall_i(push_fall_i), .push_next_i(push_next_i),
        .push_oversize_i(push_oversize_i), .push_stall_o(push_stall_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_addr_o(req_addr_o), .req_next_o(req_next_o),
        .req_last_o(req_last_o), .full_o(full_o), .empty_o(empty_o),
        .count_o(count_o), .empty_cycles_o(empty_cycles_o),
        .full_cycles_o(full_cycles_o)
    );

    // Row: {push, ready, flush, expected stall, expected count after edge}
    localparam logic [7:0] VEC [16] = '{
        8'b1000_0001, 8'b1000_0010, 8'b1000_0011, 8'b1000_0100,
        8'b1000_0101, 8'b1000_0110, 8'b1000_0111, 8'b1000_1000,
        8'b1001_1000, 8'b1100_1000, 8'b0100_0111, 8'b1100_0111,
        8'b1110_0000, 8'b0100_0000, 8'b1000_0001, 8'b1100_0001
    };

    logic [31:0] mq [D];
    int mh = 0, mt = 0, mc = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit pv, input logic [31:0] s, input logic [31:0] f,
                         input logic [31:0] n, input bit ovs, input bit rdy, input bit fl);
        @(negedge clk);
        push_valid_i = pv; push_start_i = s; push_fall_i = f; push_next_i = n;
        push_oversize_i = ovs; req_ready_i = rdy; flush_i = fl;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_req(input string req, input logic [31:0] a, input bit last);
        chk(req, {63'd0, req_valid_o}, 64'd1);
        chk(req, {32'd0, req_addr_o}, {32'd0, a});
        chk(req, {63'd0, req_last_o}, {63'd0, last});
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", {63'd0, empty_o}, 64'd1);
        chk("R1", {63'd0, full_o}, 64'd0);
        chk("R1", {60'd0, count_o}, 64'd0);
        chk("R1", {63'd0, req_valid_o}, 64'd0);
        chk("R1", {63'd0, push_stall_o}, 64'd0);
        chk("R1", {32'd0, empty_cycles_o, full_cycles_o}, 64'd0);

        // Table walk: narrow blocks, fill, overfill, swap at full, flush.
        for (int i = 0; i < 16; i++) begin
            logic [7:0]  row;
            logic [31:0] a;
            bit          pop, push;
            row = VEC[i];
            a = 32'h1000 + 32'(i) * 32'h40;
            drive(row[7], a, a + 32'h8, a + 32'h800, 1'b0, row[6], row[5]);
            chk("R5", {63'd0, push_stall_o}, {63'd0, row[4]});
            if (mc > 0) begin
                expect_req("R2", mq[mh], 1'b1);          // R3 single request per narrow block
                chk("R11", {32'd0, req_next_o}, {32'd0, mq[mh] + 32'h800});
            end else begin
                chk("R7", {63'd0, req_valid_o}, 64'd0);
            end
            tick();
            if (row[5]) begin
                mh = 0; mt = 0; mc = 0;
            end else begin
                pop  = row[6] && (mc > 0);
                push = row[7] && ((mc < D) || pop);
                if (pop) begin mh = (mh + 1) % D; mc--; end
                if (push) begin mq[mt] = a; mt = (mt + 1) % D; mc++; end
            end
            chk(row[5] ? "R8" : (i == 9 ? "R6" : "R9"), {60'd0, count_o}, {60'd0, row[3:0]});
            chk("R9", {63'd0, full_o}, {63'd0, (row[3:0] == 4'd8)});
            chk("R9", {63'd0, empty_o}, {63'd0, (row[3:0] == 4'd0)});
        end

        // Wide block split across four lines, followed by a narrow block.
        drive(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b1);
        tick();
        drive(1'b1, 32'h2008, 32'h2070, 32'h9000, 1'b1, 1'b0, 1'b0);
        tick();
        drive(1'b1, 32'h3000, 32'h3010, 32'hA000, 1'b0, 1'b1, 1'b0);
        expect_req("R4", 32'h2008, 1'b0);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        expect_req("R4", 32'h2020, 1'b0);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        expect_req("R4", 32'h2040, 1'b0);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        expect_req("R4", 32'h2060, 1'b1);
        tick();
        chk("R4", {60'd0, count_o}, 64'd2);
        drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        expect_req("R2", 32'h2060, 1'b1);
        chk("R11", {32'd0, req_next_o}, 64'h9000);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        expect_req("R2", 32'h3000, 1'b1);
        chk("R11", {32'd0, req_next_o}, 64'hA000);
        tick();
        chk("R9", {63'd0, empty_o}, 64'd1);

        // Flagged block within one line; narrow block spanning lines.
        drive(1'b1, 32'h4004, 32'h4010, 32'h0, 1'b1, 1'b0, 1'b0);
        tick();
        drive(1'b1, 32'h5010, 32'h5050, 32'h0, 1'b0, 1'b1, 1'b0);
        expect_req("R4", 32'h4004, 1'b1);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        expect_req("R3", 32'h5010, 1'b1);
        tick();
        chk("R3", {63'd0, empty_o}, 64'd1);

        // Flush in the middle of a wide block, with a competing push.
        drive(1'b1, 32'h6008, 32'h6080, 32'h0, 1'b1, 1'b0, 1'b0);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        expect_req("R4", 32'h6008, 1'b0);
        tick();
        drive(1'b1, 32'h7000, 32'h7010, 32'h0, 1'b0, 1'b1, 1'b1);
        tick();
        chk("R8", {60'd0, count_o}, 64'd0);
        chk("R8", {63'd0, req_valid_o}, 64'd0);
        drive(1'b1, 32'h7100, 32'h7110, 32'h0, 1'b0, 1'b0, 1'b0);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        expect_req("R8", 32'h7100, 1'b1);
        tick();

        // Cycle tallies and a dropped push at full.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", {32'd0, empty_cycles_o, full_cycles_o}, 64'd0);
        repeat (5) @(posedge clk);
        #1;
        chk("R10", {48'd0, empty_cycles_o}, 64'd5);
        for (int k = 0; k < D; k++) begin
            drive(1'b1, 32'hB000 + 32'(k) * 32'h40, 32'hB008 + 32'(k) * 32'h40, 32'h0, 1'b0, 1'b0, 1'b0);
            tick();
        end
        drive(1'b1, 32'hDEAD0, 32'hDEAD8, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R5", {63'd0, push_stall_o}, 64'd1);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        tick();
        drive(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R10", {48'd0, empty_cycles_o}, 64'd6);
        chk("R10", {48'd0, full_cycles_o}, 64'd3);
        chk("R5", {60'd0, count_o}, 64'd8);
        for (int k = 0; k < D; k++) begin
            drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
            expect_req("R5", 32'hB000 + 32'(k) * 32'h40, 1'b1);
            tick();
        end
        chk("R5", {63'd0, empty_o}, 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule